// File: doc/BRIEF.md
# Scan Code Set 2 Key Decoder

This block sits behind a PS/2 keyboard byte receiver. It takes one scan-code byte per valid strobe and keeps track of the break (F0), extended (E0) and Pause (E1) prefixes. When a byte completes a key event, the block converts that event into a compact key number and a make/break flag. It also keeps the three keyboard lock toggles: Caps, Num and Scroll.

Each finished event produces a two-byte keyboard report on a registered output. The report is valid for one cycle, and a downstream serial transmitter picks it up there. Only a representative subset of keys is mapped. Bytes that cannot be resolved give no report.

Top module: `ps2_set2_decoder`

## Requirements
- R1: After reset `rpt_valid` is 0, all three locks are off and no prefix is pending, so the first plain make reports locks 000.
- R2: An unprefixed known code gives a make report (flag 1) one cycle after its byte is accepted. Plain mappings: 1C→4, 32→5, 21→6, 23→7, 5A→40, 76→41, 66→42, 0D→43, 29→44, 05→58, 58→57, 77→83, 7E→71, 14→165, 12→166, 11→167, 59→170.
- R3: F0 followed by a known code gives a break report (flag 0) with the same key number as the make.
- R4: E0 selects the extended map for make, and E0 F0 selects it for break. Extended mappings: 74→79, 6B→80, 72→81, 75→82, 14→169, 11→171, 5A→88, 4A→84.
- R5: The eight bytes E1 14 77 E1 F0 14 F0 77 give exactly one report, key 72 with make flag 1. The bytes in the middle of the sequence give no report and do not change any lock. A byte that does not match the next expected byte abandons the sequence and is decoded as if no prefix were pending.
- R6: An unprefixed 00 reports key 1 and an unprefixed FC reports key 2, both with the make flag set even if F0 came before.
- R7: An unmapped code gives no report and clears every pending prefix.
- R8: Report layout. Byte 0 is {1, 1, 0, caps, num, scroll, key[7], make}. Byte 1 is {0, key[6:0]}.
- R9: The make of key 57 toggles Caps, key 83 toggles Num and key 71 toggles Scroll. The report for that make already carries the new lock value.
- R10: A repeated make of a lock key with no break in between does not toggle again. A break leaves all locks unchanged and re-arms the toggle.
- R11: A new prefix byte drops any prefix still pending. E0 clears a pending F0, and a stray F0 before E0 74 yields the make of key 79.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | Byte strobe from the receiver |
| code_byte | input | 8 | Received scan-code byte |
| rpt_valid | output | 1 | One-cycle pulse, report bytes valid |
| rpt_b0 | output | 8 | Report byte 0: tag, locks, key bit 7, make flag |
| rpt_b1 | output | 8 | Report byte 1: key bits 6..0 |

## Verification
A wrong prefix state shows up at the next report. The direction flips from make to break, an extended key returns its plain number, or a report appears or goes missing one cycle after a byte that should have done the opposite. A wrong lock or hold bit stays hidden until the next report of any key, which then carries the wrong lock field. For that reason every lock-affecting step in the stimulus is followed by an ordinary key report. Pause bytes are checked both as a full sequence and as a broken one, so a sequence index that slips surfaces as a spurious or missing key-72 report.

// File: rtl/ps2_set2_decoder.sv
module ps2_set2_decoder #(
  parameter int BYTE_W  = 8,
  parameter int PSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  input  logic [BYTE_W-1:0] code_byte,
  output logic              rpt_valid,
  output logic [7:0]        rpt_b0,
  output logic [7:0]        rpt_b1
);
  localparam int IDX_W = $clog2(PSE_LEN);
  localparam logic [7:0] K_PAUSE  = 8'd72;
  localparam logic [7:0] K_CAPS   = 8'd57;
  localparam logic [7:0] K_NUM    = 8'd83;
  localparam logic [7:0] K_SCROLL = 8'd71;

  function automatic logic [8:0] key_of(input logic ext, input logic [7:0] c);
    if (!ext) begin
      case (c)
        8'h00: return {1'b1, 8'd1};
        8'hFC: return {1'b1, 8'd2};
        8'h1C: return {1'b1, 8'd4};
        8'h32: return {1'b1, 8'd5};
        8'h21: return {1'b1, 8'd6};
        8'h23: return {1'b1, 8'd7};
        8'h5A: return {1'b1, 8'd40};
        8'h76: return {1'b1, 8'd41};
        8'h66: return {1'b1, 8'd42};
        8'h0D: return {1'b1, 8'd43};
        8'h29: return {1'b1, 8'd44};
        8'h05: return {1'b1, 8'd58};
        8'h58: return {1'b1, 8'd57};
        8'h77: return {1'b1, 8'd83};
        8'h7E: return {1'b1, 8'd71};
        8'h14: return {1'b1, 8'd165};
        8'h12: return {1'b1, 8'd166};
        8'h11: return {1'b1, 8'd167};
        8'h59: return {1'b1, 8'd170};
        default: return 9'd0;
      endcase
    end else begin
      case (c)
        8'h74: return {1'b1, 8'd79};
        8'h6B: return {1'b1, 8'd80};
        8'h72: return {1'b1, 8'd81};
        8'h75: return {1'b1, 8'd82};
        8'h14: return {1'b1, 8'd169};
        8'h11: return {1'b1, 8'd171};
        8'h5A: return {1'b1, 8'd88};
        8'h4A: return {1'b1, 8'd84};
        default: return 9'd0;
      endcase
    end
  endfunction

  function automatic logic [7:0] pause_byte(input logic [IDX_W-1:0] i);
    case (i)
      3'd0, 3'd3: return 8'hE1;
      3'd1, 3'd5: return 8'h14;
      3'd2, 3'd7: return 8'h77;
      default:    return 8'hF0;
    endcase
  endfunction

  logic             ext_q, brk_q;
  logic [IDX_W-1:0] pse_q;
  logic [2:0]       lk_q, held_q;

  logic       in_pause, pause_hit, pause_done, plain_path;
  logic       is_e0, is_f0, is_e1, is_prefix, special;
  logic [8:0] look;
  logic       fire, ev_make;
  logic [7:0] ev_key;
  logic [2:0] sel, lk_n, held_n;

  wire [7:0] b = code_byte[7:0];

  assign in_pause   = (pse_q != '0);
  assign pause_hit  = in_pause && (b == pause_byte(pse_q));
  assign pause_done = pause_hit && (pse_q == IDX_W'(PSE_LEN - 1));
  assign plain_path = !pause_hit;

  assign is_e0     = (b == 8'hE0);
  assign is_f0     = (b == 8'hF0);
  assign is_e1     = (b == 8'hE1);
  assign is_prefix = is_e0 | is_f0 | is_e1;
  assign look      = key_of(ext_q, b);
  assign special   = !ext_q && (b == 8'h00 || b == 8'hFC);

  assign fire    = pause_done || (plain_path && !is_prefix && look[8]);
  assign ev_key  = pause_done ? K_PAUSE : look[7:0];
  assign ev_make = pause_done || special || !brk_q;

  assign sel = fire ? {ev_key == K_CAPS, ev_key == K_NUM, ev_key == K_SCROLL} : 3'b000;

  always_comb begin
    lk_n   = lk_q;
    held_n = held_q;
    for (int i = 0; i < 3; i++) begin
      if (sel[i] && ev_make && !held_q[i]) begin
        lk_n[i]   = ~lk_q[i];
        held_n[i] = 1'b1;
      end else if (sel[i] && !ev_make) begin
        held_n[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q     <= 1'b0;
      brk_q     <= 1'b0;
      pse_q     <= '0;
      lk_q      <= 3'b000;
      held_q    <= 3'b000;
      rpt_valid <= 1'b0;
      rpt_b0    <= 8'h00;
      rpt_b1    <= 8'h00;
    end else begin
      rpt_valid <= code_valid && fire;
      if (code_valid) begin
        lk_q   <= lk_n;
        held_q <= held_n;
        if (pause_hit) begin
          pse_q <= pause_done ? '0 : pse_q + 1'b1;
          ext_q <= 1'b0;
          brk_q <= 1'b0;
        end else if (is_e0) begin
          pse_q <= '0;
          ext_q <= 1'b1;
          brk_q <= 1'b0;
        end else if (is_f0) begin
          pse_q <= '0;
          brk_q <= 1'b1;
        end else if (is_e1) begin
          pse_q <= IDX_W'(1);
          ext_q <= 1'b0;
          brk_q <= 1'b0;
        end else begin
          pse_q <= '0;
          ext_q <= 1'b0;
          brk_q <= 1'b0;
        end
        if (fire) begin
          rpt_b0 <= {2'b11, 1'b0, lk_n, ev_key[7], ev_make};
          rpt_b1 <= {1'b0, ev_key[6:0]};
        end
      end
    end
  end
endmodule

// File: rtl/ps2_set2_decoder_chk.sv
module ps2_set2_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       code_valid,
  input logic       rpt_valid,
  input logic [7:0] rpt_b0,
  input logic [7:0] rpt_b1,
  input logic [2:0] lk
);
  AST_REPORT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> (rpt_b0[7:5] == 3'b110) && !rpt_b1[7]); // R8
  AST_REPORT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> $past(code_valid)); // R2
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |=> $stable(lk)); // R9
  AST_LOCK_IN_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> rpt_b0[4:2] == lk); // R9
  AST_BREAK_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_b0[0]) |-> rpt_b0[4:2] == $past(lk)); // R10
  AST_PAUSE_IS_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_b0[1] && rpt_b1[6:0] == 7'd72) |-> rpt_b0[0]); // R5
endmodule

bind ps2_set2_decoder ps2_set2_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .code_valid(code_valid),
  .rpt_valid(rpt_valid), .rpt_b0(rpt_b0), .rpt_b1(rpt_b1), .lk(lk_q)
);

// File: tb/ps2_set2_decoder_tb.sv
module ps2_set2_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_valid = 1'b0;
  logic [7:0] code_byte = 8'h00;
  logic       rpt_valid;
  logic [7:0] rpt_b0, rpt_b1;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic ec = 0, en = 0, es = 0;

  always #5 clk = ~clk;

  ps2_set2_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_byte(code_byte),
    .rpt_valid(rpt_valid), .rpt_b0(rpt_b0), .rpt_b1(rpt_b1)
  );

  task automatic expect_rpt(input string tag, input logic mk, input logic [7:0] key);
    exp_q.push_back({2'b11, 1'b0, ec, en, es, key[7], mk, 1'b0, key[6:0]});
    tag_q.push_back(tag);
  endtask

  task automatic put(input logic [7:0] b, input int gap = 2);
    code_valid = 1'b1;
    code_byte  = b;
    @(negedge clk);
    code_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rpt_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected report actual=%h_%h expected=none", rpt_b0, rpt_b1);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rpt_b0, rpt_b1} !== e) begin
          errors++;
          $display("FAIL %s actual=%h_%h expected=%h_%h", t, rpt_b0, rpt_b1, e[15:8], e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rpt_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rpt_valid in reset actual=%b expected=0", rpt_valid);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (rpt_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rpt_valid after reset actual=%b expected=0", rpt_valid);
    end

    // R1 R2 plain makes, locks off
    expect_rpt("R1 first make", 1, 8'd4);   put(8'h1C);
    expect_rpt("R2 B make", 1, 8'd5);       put(8'h32);
    expect_rpt("R2 Return make", 1, 8'd40); put(8'h5A);
    // R3 break
    put(8'hF0); expect_rpt("R3 A break", 0, 8'd4); put(8'h1C);
    // R4 extended
    put(8'hE0); expect_rpt("R4 RightArrow make", 1, 8'd79); put(8'h74);
    put(8'hE0, 0); put(8'hF0, 0);
    expect_rpt("R4 RightArrow break back-to-back", 0, 8'd79); put(8'h74);
    expect_rpt("R8 LeftCtrl key bit7", 1, 8'd165); put(8'h14);
    put(8'hE0); expect_rpt("R4 RightCtrl make", 1, 8'd169); put(8'h14);
    put(8'hE0); put(8'hF0); expect_rpt("R4 RightCtrl break", 0, 8'd169); put(8'h14);
    put(8'hF0); expect_rpt("R3 LeftCtrl break", 0, 8'd165); put(8'h14);
    // R9 R10 locks
    ec = 1; expect_rpt("R9 Caps toggles on", 1, 8'd57); put(8'h58);
    expect_rpt("R10 Caps repeat no toggle", 1, 8'd57); put(8'h58);
    put(8'hF0); expect_rpt("R10 Caps break keeps lock", 0, 8'd57); put(8'h58);
    ec = 0; expect_rpt("R10 Caps rearmed toggles off", 1, 8'd57); put(8'h58);
    put(8'hF0); expect_rpt("R10 Caps break", 0, 8'd57); put(8'h58);
    en = 1; expect_rpt("R9 Num on", 1, 8'd83); put(8'h77);
    put(8'hF0); expect_rpt("R9 Num break", 0, 8'd83); put(8'h77);
    es = 1; expect_rpt("R9 Scroll on", 1, 8'd71); put(8'h7E);
    put(8'hF0); expect_rpt("R9 Scroll break", 0, 8'd71); put(8'h7E);
    // R5 pause
    put(8'hE1); put(8'h14); put(8'h77); put(8'hE1);
    put(8'hF0); put(8'h14); put(8'hF0);
    expect_rpt("R5 Pause single make", 1, 8'd72); put(8'h77);
    expect_rpt("R5 Num untouched by pause bytes", 1, 8'd4); put(8'h1C);
    put(8'hE1); put(8'h14);
    expect_rpt("R5 broken pause decodes byte", 1, 8'd4); put(8'h1C);
    // R6 special codes
    expect_rpt("R6 overrun", 1, 8'd1); put(8'h00);
    put(8'hF0); expect_rpt("R6 selftest fail make even after F0", 1, 8'd2); put(8'hFC);
    // R7 unknown codes clear prefixes
    put(8'hE0); put(8'h0E);
    expect_rpt("R7 ext cleared by unknown", 1, 8'd40); put(8'h5A);
    put(8'hF0); put(8'h0E);
    expect_rpt("R7 break cleared by unknown", 1, 8'd4); put(8'h1C);
    // R11 stray prefixes
    put(8'hF0); put(8'hE0);
    expect_rpt("R11 stray F0 dropped by E0", 1, 8'd79); put(8'h74);
    put(8'hE1); put(8'hE0);
    expect_rpt("R11 stray E1 dropped by E0", 1, 8'd79); put(8'h74);

    repeat (5) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing reports actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule